// File: doc/BRIEF.md
# GPIO Controller with Change Interrupts

This block is a register-mapped general-purpose I/O controller for a parameterised number of lines (at most 32). It sits on a 32-bit register bus that uses word-aligned reads and writes. Each line has a direction bit that selects between input and output. A single data register drives the output lines. Reading that register returns the driven value on output lines and the synchronised pin level on input lines.

Every input line passes through a two-stage synchroniser and then an edge detector. A rising or a falling edge sets a sticky bit in the change register. Software acknowledges a change bit by writing a one to it. A separate enable register masks the change bits, and the OR of the bits that stay unmasked drives one registered, level-sensitive interrupt output. A write-mask register limits which data bits a data write can modify. A read-only type register reports that every line works in both-edge mode.

Top module: `gpio_chg_ctrl`

## Requirements
- R1: Synchronous reset clears direction, data, enable and change registers to zero and sets the write mask to all ones for the implemented lines. After reset, pin_oe and irq are 0.
- R2: Direction bit value 1 makes the line an output: pin_oe is 1 and pin_out carries the data bit. Value 0 makes the line an input and pin_oe is 0.
- R3: A read asserts rsp_rvalid with rsp_rdata on the cycle after the request. A data read returns the driven bit for output lines and the synchronised pin value for input lines.
- R4: A data write changes only the bits whose write-mask bit is 1. The write mask is itself readable and writable.
- R5: A rising or falling edge on an input line sets its change bit. The pin passes through a two-flop synchroniser first. Pin changes on output lines set no change bit.
- R6: Writing 1 to a change bit clears it. Writing 0 leaves the bit unchanged.
- R7: irq is a registered OR of (change AND enable). It stays high while any enabled change bit is set, and it drops once every such bit is cleared or masked.
- R8: When an edge and a clearing write hit the same change bit in the same cycle, the edge wins and the bit stays set.
- R9: The type register always reads ones in every implemented bit position, meaning both-edge mode. Writes to it have no effect.
- R10: Register bits at or above NL read as zero and ignore writes.
- R11: Byte offsets are 0x00 direction, 0x04 data, 0x08 enable, 0x0C change, 0x10 write mask and 0x14 type. Any other address, including one with address bits [1:0] not zero, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Write strobe |
| req_rd | input | 1 | Read strobe |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| rsp_rvalid | output | 1 | Read data valid, one cycle after req_rd |
| pin_in | input | NL | Pin levels from the pads |
| pin_out | output | NL | Driven output values |
| pin_oe | output | NL | Output enables (1 = drive) |
| irq | output | 1 | Level interrupt |

## Verification
The bench raises and then lowers one input line at a time, so a change bit has to appear for each edge direction separately. Toggling a line configured as an output separates edge gating by direction from plain edge detection. Pin patterns that differ from the driven data show whether a data read takes each bit from the pin or from the register. A falling edge timed to meet an acknowledge write in the same cycle separates edge priority from clear priority. Two lines pending at once, one of them then acknowledged, show that the interrupt is an OR and not a single flag.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

  // Word index taken from byte address bits [4:2]
  typedef enum logic [2:0] {
    SEL_DIR   = 3'd0,
    SEL_DATA  = 3'd1,
    SEL_EN    = 3'd2,
    SEL_CHG   = 3'd3,
    SEL_WMASK = 3'd4,
    SEL_TYPE  = 3'd5
  } reg_sel_e;

  localparam int unsigned BUS_W = 32;

endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
  parameter int unsigned NL     = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] pin_in,
  output logic [NL-1:0] sync_o,
  output logic [NL-1:0] edge_o
);

  logic [NL-1:0] raw_edge;
  // Edge output is held off until the chain and the history flop are primed
  logic [STAGES:0] arm_q;

  always_ff @(posedge clk) begin
    if (rst) arm_q <= '0;
    else     arm_q <= {arm_q[STAGES-1:0], 1'b1};
  end

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], pin_in[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end
    assign sync_o[g]   = chain_q[STAGES-1];
    assign raw_edge[g] = chain_q[STAGES-1] ^ prev_q;
  end

  assign edge_o = arm_q[STAGES] ? raw_edge : '0;

endmodule

// File: rtl/gpio_chg_regs.sv
module gpio_chg_regs
  import gpio_chg_pkg::*;
#(
  parameter int unsigned NL = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  reg_sel_e      sel,
  input  logic [NL-1:0] wval,
  output logic [NL-1:0] dir_q,
  output logic [NL-1:0] data_q,
  output logic [NL-1:0] en_q,
  output logic [NL-1:0] wmask_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      data_q  <= '0;
      en_q    <= '0;
      wmask_q <= '1;
    end else if (wr_en) begin
      case (sel)
        SEL_DIR:   dir_q   <= wval;
        SEL_DATA:  data_q  <= (data_q & ~wmask_q) | (wval & wmask_q);
        SEL_EN:    en_q    <= wval;
        SEL_WMASK: wmask_q <= wval;
        default:   ;
      endcase
    end
  end

  // R4
  masked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_DATA) |=>
      ((data_q & ~$past(wmask_q)) == ($past(data_q) & ~$past(wmask_q))));

endmodule

// File: rtl/gpio_chg_event.sv
module gpio_chg_event #(
  parameter int unsigned NL = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] edge_i,
  input  logic [NL-1:0] dir_i,
  input  logic [NL-1:0] en_i,
  input  logic          clr_wr,
  input  logic [NL-1:0] wval,
  output logic [NL-1:0] chg_q,
  output logic          irq_q
);

  logic [NL-1:0] seen;
  logic [NL-1:0] clr_bits;

  assign seen     = edge_i & ~dir_i;
  assign clr_bits = clr_wr ? wval : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      chg_q <= (chg_q & ~clr_bits) | seen;
      irq_q <= |(chg_q & en_i);
    end
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seen == '0 && !clr_wr) |=> $stable(chg_q));

  // R6
  ack_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && seen == '0) |=> ((chg_q & $past(wval)) == '0));

  // R8
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && (seen & wval) != '0) |=>
      ((chg_q & $past(seen & wval)) == $past(seen & wval)));

endmodule

// File: rtl/gpio_chg_ctrl.sv
module gpio_chg_ctrl
  import gpio_chg_pkg::*;
#(
  parameter int unsigned NL     = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              rsp_rvalid,
  input  logic [NL-1:0]     pin_in,
  output logic [NL-1:0]     pin_out,
  output logic [NL-1:0]     pin_oe,
  output logic              irq
);

  localparam logic [BUS_W-1:0] LINE_MASK =
    (NL >= BUS_W) ? {BUS_W{1'b1}} : ((BUS_W'(1) << NL) - BUS_W'(1));

  function automatic logic [BUS_W-1:0] widen(input logic [NL-1:0] v);
    widen = '0;
    widen[NL-1:0] = v;
  endfunction

  logic          hit;
  reg_sel_e      sel;
  logic          wr_hit;
  logic [NL-1:0] wval;
  logic [NL-1:0] sync_v, edge_v;
  logic [NL-1:0] dir_q, data_q, en_q, wmask_q, chg_q;
  logic [BUS_W-1:0] rd_word;
  logic [BUS_W-1:0] rdata_q;
  logic             rvalid_q;

  assign hit    = (req_addr[ADDR_W-1:5] == '0) && (req_addr[1:0] == 2'b00);
  assign sel    = reg_sel_e'(req_addr[4:2]);
  assign wr_hit = req_wr && hit;
  assign wval   = req_wdata[NL-1:0];

  gpio_chg_sync #(.NL(NL), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sync_o(sync_v), .edge_o(edge_v)
  );

  gpio_chg_regs #(.NL(NL)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_hit), .sel(sel), .wval(wval),
    .dir_q(dir_q), .data_q(data_q), .en_q(en_q), .wmask_q(wmask_q)
  );

  gpio_chg_event #(.NL(NL)) u_event (
    .clk(clk), .rst(rst), .edge_i(edge_v), .dir_i(dir_q), .en_i(en_q),
    .clr_wr(wr_hit && sel == SEL_CHG), .wval(wval),
    .chg_q(chg_q), .irq_q(irq)
  );

  always_comb begin
    rd_word = '0;
    if (hit) begin
      case (sel)
        SEL_DIR:   rd_word = widen(dir_q);
        SEL_DATA:  rd_word = widen((dir_q & data_q) | (~dir_q & sync_v));
        SEL_EN:    rd_word = widen(en_q);
        SEL_CHG:   rd_word = widen(chg_q);
        SEL_WMASK: rd_word = widen(wmask_q);
        SEL_TYPE:  rd_word = LINE_MASK;
        default:   rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_rd;
      if (req_rd) rdata_q <= rd_word;
    end
  end

  assign rsp_rdata  = rdata_q;
  assign rsp_rvalid = rvalid_q;
  assign pin_out    = data_q;
  assign pin_oe     = dir_q;

  // R3
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    req_rd |=> rsp_rvalid);

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_rvalid |-> ((rsp_rdata & ~LINE_MASK) == '0));

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq);

endmodule

// File: tb/sim_gpio_chg_ctrl.sv
module sim_gpio_chg_ctrl;
  localparam int unsigned NL = 12;
  localparam logic [31:0] ALL = 32'h0000_0FFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_wr = 1'b0, req_rd = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rsp_rdata;
  logic          rsp_rvalid;
  logic [NL-1:0] pin_in = '0;
  logic [NL-1:0] pin_out, pin_oe;
  logic          irq;
  int            errs = 0, checks = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  gpio_chg_ctrl #(.NL(NL), .ADDR_W(8), .STAGES(2)) u0 (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_rvalid(rsp_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk); req_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req_rd = 1'b1; req_addr = a;
    @(posedge clk);
    @(negedge clk); req_rd = 1'b0; d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_pins(input logic [NL-1:0] v);
    @(negedge clk); pin_in = v;
    idle(5);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 irq", 32'(irq), 0);
    @(negedge clk); req_rd = 1'b1; req_addr = 8'h00;
    @(posedge clk); @(negedge clk); req_rd = 1'b0;
    chk("R3 rvalid", 32'(rsp_rvalid), 1);
    chk("R1 dir", rsp_rdata, 0);
    rd(8'h04, d); chk("R1 data", d, 0);
    rd(8'h08, d); chk("R1 enable", d, 0);
    rd(8'h0C, d); chk("R1 change", d, 0);
    rd(8'h10, d); chk("R1 wmask", d, ALL);
  endtask

  task automatic t_dir_data();
    logic [31:0] d;
    wr(8'h00, 32'h00F);
    wr(8'h04, 32'h005);
    chk("R2 pin_oe", 32'(pin_oe), 32'h00F);
    chk("R2 pin_out", 32'(pin_out) & 32'hF, 32'h5);
    set_pins(12'hA5A);
    rd(8'h04, d); chk("R3 data mix", d, 32'hA55);
    set_pins(12'h000);
    rd(8'h04, d); chk("R3 data inputs low", d, 32'h005);
  endtask

  task automatic t_wmask();
    logic [31:0] d;
    wr(8'h10, 32'h003);
    rd(8'h10, d); chk("R4 wmask readback", d, 32'h003);
    wr(8'h04, 32'hFFF);
    chk("R4 masked write", 32'(pin_out), 32'h007);
    wr(8'h10, 32'hFFF);
    wr(8'h04, 32'h000);
    chk("R4 full mask", 32'(pin_out), 32'h000);
    wr(8'h00, 32'h000);
    idle(3);
    wr(8'h0C, 32'hFFF);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    rd(8'h0C, d); chk("R5 clean start", d, 0);
    set_pins(12'h002);
    rd(8'h0C, d); chk("R5 rising", d, 32'h002);
    wr(8'h0C, 32'h002);
    set_pins(12'h000);
    rd(8'h0C, d); chk("R5 falling", d, 32'h002);
    wr(8'h0C, 32'h002);
    wr(8'h00, 32'h100);
    set_pins(12'h100);
    set_pins(12'h000);
    rd(8'h0C, d); chk("R5 output line no edge", d, 0);
    wr(8'h00, 32'h000);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    set_pins(12'h024);
    rd(8'h0C, d); chk("R6 two set", d, 32'h024);
    wr(8'h0C, 32'h004);
    rd(8'h0C, d); chk("R6 one cleared", d, 32'h020);
    wr(8'h0C, 32'h000);
    rd(8'h0C, d); chk("R6 zero write no effect", d, 32'h020);
    wr(8'h0C, 32'h020);
    rd(8'h0C, d); chk("R6 all cleared", d, 0);
    set_pins(12'h000);
    wr(8'h0C, 32'hFFF);
  endtask

  task automatic t_irq();
    set_pins(12'h008);
    chk("R7 masked no irq", 32'(irq), 0);
    wr(8'h08, 32'h008); idle(2);
    chk("R7 enabled irq", 32'(irq), 1);
    wr(8'h08, 32'h000); idle(2);
    chk("R7 masked again", 32'(irq), 0);
    wr(8'h08, 32'h018);
    set_pins(12'h018);
    chk("R7 two pending", 32'(irq), 1);
    wr(8'h0C, 32'h008); idle(2);
    chk("R7 one left pending", 32'(irq), 1);
    wr(8'h0C, 32'h010); idle(2);
    chk("R7 all acked", 32'(irq), 0);
    wr(8'h08, 32'h000);
    set_pins(12'h000);
    wr(8'h0C, 32'hFFF);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    set_pins(12'h040);
    rd(8'h0C, d); chk("R8 setup", d, 32'h040);
    @(negedge clk); pin_in = 12'h000;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); req_wr = 1'b1; req_addr = 8'h0C; req_wdata = 32'h040;
    @(posedge clk);
    @(negedge clk); req_wr = 1'b0;
    rd(8'h0C, d); chk("R8 edge wins", d, 32'h040);
    wr(8'h0C, 32'h040);
    rd(8'h0C, d); chk("R8 plain clear", d, 0);
  endtask

  task automatic t_type();
    logic [31:0] d;
    rd(8'h14, d); chk("R9 type", d, ALL);
    wr(8'h14, 32'h0);
    rd(8'h14, d); chk("R9 type after write", d, ALL);
  endtask

  task automatic t_upper_unmapped();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R10 upper dir bits", d, ALL);
    chk("R10 pin_oe", 32'(pin_oe), ALL);
    wr(8'h08, 32'hFFFF_F000);
    rd(8'h08, d); chk("R10 upper enable bits", d, 0);
    rd(8'h18, d); chk("R11 unmapped read", d, 0);
    wr(8'h18, 32'h0);
    wr(8'h01, 32'h0);
    wr(8'h20, 32'h0);
    rd(8'h00, d); chk("R11 stray writes ignored", d, ALL);
    rd(8'h02, d); chk("R11 misaligned read", d, 0);
    wr(8'h00, 32'h0);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(4);
    t_reset();
    t_dir_data();
    t_wmask();
    t_edges();
    t_ack();
    t_irq();
    t_collision();
    t_type();
    t_upper_unmapped();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule